// File: doc/BRIEF.md
# Handshaked I/Q Sample Output Port

This block takes complex baseband samples from up to eight gain-control channels and sends them to a receiving processor over one 16-bit parallel bus. Each channel presents a valid strobe with its I, Q and 12-bit gain values. The port keeps the newest sample of each channel in its own slot until that sample has been sent. Pending slots are served in ascending channel order. Every transfer starts with a request cycle, and the bus moves forward only on clock edges where the receiver's acknowledge is high.

There are two output formats. In interleaved format the bus carries a 16-bit I beat and then a 16-bit Q beat. When the gain beat is enabled, a third beat follows with the gain value in the upper twelve bits. In packed format the bus carries the top byte of I and the top byte of Q together in one beat. Channels that are pending back to back stream out one beat after another, and the I flag stays high between them. A 3-bit channel field names the source of every data beat. A sticky per-channel overflow bit records each sample that replaced one not yet sent.

Top module: `iq_out_port`

## Requirements
- R1: During and after reset, `req_o`, `iq_flag_o`, `gain_flag_o`, `bus_o`, `chan_o` and `ovf_o` are all zero.
- R2: A transfer opens with one idle cycle (`req_o` low) and then a request cycle (`req_o` high, bus zero, both flags low). `req_o` stays high through the final beat of the transfer and is low in the cycle after it.
- R3: In interleaved format (`par_mode_i`=0), if acknowledge is high during the request cycle, the next cycle shows the channel's 16-bit I value on `bus_o`, with `iq_flag_o`=1 and `chan_o` equal to the channel number in binary.
- R4: In interleaved format, the cycle after an acknowledged I beat shows the Q value, with `iq_flag_o`=0 and the same `chan_o`.
- R5: With `gain_en_i`=1 in interleaved format, the cycle after an acknowledged Q beat shows {gain[11:0], 4'b0000}, with `gain_flag_o`=1 in that cycle only. With `gain_en_i`=0 the transfer ends after Q, so one sample uses 3 cycles of `req_o`.
- R6: While acknowledge is low, `req_o` stays high and `bus_o`, `iq_flag_o`, `gain_flag_o` and `chan_o` do not change.
- R7: In packed format (`par_mode_i`=1), each data beat shows {I[15:8], Q[15:8]} with `iq_flag_o`=1 and `gain_flag_o`=0, whatever `gain_en_i` is. Pending channels follow one per cycle with the flag held high, and the flag drops in the cycle after the last one.
- R8: When several channels are pending, they are sent in ascending channel-number order.
- R9: A sample that arrives while the port is busy is kept and sent later. If the channel already has an unsent sample, the newer sample replaces it and that channel's bit in `ovf_o` sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode_i | input | 1 | 1 = packed 8+8 format, 0 = interleaved format |
| gain_en_i | input | 1 | Adds the gain beat in interleaved format |
| smp_vld_i | input | 8 | Per-channel sample strobe |
| smp_i_i | input | 128 | I values, channel k in bits [16k+15:16k] |
| smp_q_i | input | 128 | Q values, channel k in bits [16k+15:16k] |
| smp_gain_i | input | 96 | Gain values, channel k in bits [12k+11:12k] |
| ack_i | input | 1 | Receiver acknowledge |
| req_o | output | 1 | Transfer request |
| bus_o | output | 16 | Data bus |
| iq_flag_o | output | 1 | High on I beats and on packed beats |
| gain_flag_o | output | 1 | High on the gain beat |
| chan_o | output | 3 | Source channel of the current data beat |
| ovf_o | output | 8 | Sticky per-channel overwrite bits |

## Verification
A strobe applied before clock edge E is stored at E. The port is idle in the cycle after E. `req_o` rises one edge later. Each data beat then appears one edge after the previous beat or request cycle was acknowledged. An overflow bit is visible in the cycle after the strobe that caused it. The bench drives inputs and samples outputs at falling edges, and it steps through a burst one falling edge per expected cycle. Each cycle's full output set is compared with values computed from the channel mask and the format. The sweep covers every non-empty channel mask in all three formats, and a directed sequence stalls acknowledge during the request and data beats.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;

    // Beat sequencer states. ST_PAR is the packed 8+8 beat.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_I    = 3'd2,
        ST_Q    = 3'd3,
        ST_G    = 3'd4,
        ST_PAR  = 3'd5
    } beat_st_e;

endpackage

// File: rtl/iq_slot_store.sv
module iq_slot_store #(
    parameter int NCH = 8,
    parameter int SW  = 16,
    parameter int GW  = 12,
    parameter int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    vld_i,
    input  logic [NCH*SW-1:0] i_i,
    input  logic [NCH*SW-1:0] q_i,
    input  logic [NCH*GW-1:0] g_i,
    input  logic              pop_i,
    input  logic [CHW-1:0]    pop_idx_i,
    output logic [NCH-1:0]    pend_o,
    output logic [NCH-1:0]    ovf_o,
    output logic [SW-1:0]     rd_i_o,
    output logic [SW-1:0]     rd_q_o,
    output logic [GW-1:0]     rd_g_o
);

    typedef struct packed {
        logic [NCH-1:0]         pend;
        logic [NCH-1:0]         ovf;
        logic [NCH-1:0][SW-1:0] i;
        logic [NCH-1:0][SW-1:0] q;
        logic [NCH-1:0][GW-1:0] g;
    } store_t;

    store_t st_d, st_q;
    logic [NCH-1:0] clr;

    // One pop decoder per slot.
    for (genvar k = 0; k < NCH; k++) begin : g_clr
        assign clr[k] = pop_i && (pop_idx_i == CHW'(k));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCH; k++) begin
            if (clr[k]) st_d.pend[k] = 1'b0;
            if (vld_i[k]) begin
                // An unsent sample that is not leaving this cycle is replaced.
                if (st_q.pend[k] && !clr[k]) st_d.ovf[k] = 1'b1;
                st_d.pend[k] = 1'b1;
                st_d.i[k]    = i_i[k*SW +: SW];
                st_d.q[k]    = q_i[k*SW +: SW];
                st_d.g[k]    = g_i[k*GW +: GW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign ovf_o  = st_q.ovf;
    assign rd_i_o = st_q.i[pop_idx_i];
    assign rd_q_o = st_q.q[pop_idx_i];
    assign rd_g_o = st_q.g[pop_idx_i];

    // R8: the sequencer only takes a slot that holds a sample.
    p_pop_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> st_q.pend[pop_idx_i]);

    // R9: overflow bits never clear outside reset.
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ovf & $past(st_q.ovf)) == $past(st_q.ovf)));

endmodule

// File: rtl/iq_prio_pick.sv
module iq_prio_pick #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend_i,
    output logic           any_o,
    output logic [CHW-1:0] idx_o
);

    // Lowest pending index wins.
    always_comb begin
        idx_o = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (pend_i[k]) idx_o = CHW'(k);
        end
    end

    assign any_o = |pend_i;

    // R8: the chosen slot is pending and no lower slot is.
    p_lowest_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (pend_i[idx_o] &&
                   ((pend_i & ((NCH'(1) << idx_o) - NCH'(1))) == '0)));

endmodule

// File: rtl/iq_beat_seq.sv
module iq_beat_seq
    import iq_port_pkg::*;
#(
    parameter int SW  = 16,
    parameter int GW  = 12,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_mode_i,
    input  logic           gain_en_i,
    input  logic           ack_i,
    input  logic           any_i,
    input  logic [CHW-1:0] idx_i,
    input  logic [SW-1:0]  rd_i_i,
    input  logic [SW-1:0]  rd_q_i,
    input  logic [GW-1:0]  rd_g_i,
    output logic           pop_o,
    output logic           req_o,
    output logic [SW-1:0]  bus_o,
    output logic           iq_flag_o,
    output logic           gain_flag_o,
    output logic [CHW-1:0] chan_o
);

    localparam int HB   = SW / 2;
    localparam int PADW = SW - GW;

    typedef struct packed {
        beat_st_e       st;
        logic [CHW-1:0] ch;
        logic [SW-1:0]  i;
        logic [SW-1:0]  q;
        logic [GW-1:0]  g;
    } seq_t;

    seq_t sq_d, sq_q;
    logic data_beat;

    always_comb begin
        sq_d  = sq_q;
        pop_o = 1'b0;
        unique case (sq_q.st)
            ST_IDLE: begin
                if (any_i) begin
                    pop_o   = 1'b1;
                    sq_d.ch = idx_i;
                    sq_d.i  = rd_i_i;
                    sq_d.q  = rd_q_i;
                    sq_d.g  = rd_g_i;
                    sq_d.st = ST_REQ;
                end
            end
            ST_REQ: if (ack_i) sq_d.st = par_mode_i ? ST_PAR : ST_I;
            ST_I:   if (ack_i) sq_d.st = ST_Q;
            ST_Q:   if (ack_i) sq_d.st = gain_en_i ? ST_G : ST_IDLE;
            ST_G:   if (ack_i) sq_d.st = ST_IDLE;
            ST_PAR: begin
                if (ack_i) begin
                    if (any_i) begin
                        // Chain the next pending channel without a new request.
                        pop_o   = 1'b1;
                        sq_d.ch = idx_i;
                        sq_d.i  = rd_i_i;
                        sq_d.q  = rd_q_i;
                        sq_d.g  = rd_g_i;
                    end else begin
                        sq_d.st = ST_IDLE;
                    end
                end
            end
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign data_beat = (sq_q.st == ST_I) || (sq_q.st == ST_Q) ||
                       (sq_q.st == ST_G) || (sq_q.st == ST_PAR);

    always_comb begin
        unique case (sq_q.st)
            ST_I:    bus_o = sq_q.i;
            ST_Q:    bus_o = sq_q.q;
            ST_G:    bus_o = {sq_q.g, {PADW{1'b0}}};
            ST_PAR:  bus_o = {sq_q.i[SW-1 -: HB], sq_q.q[SW-1 -: HB]};
            default: bus_o = '0;
        endcase
    end

    assign req_o       = (sq_q.st != ST_IDLE);
    assign iq_flag_o   = (sq_q.st == ST_I) || (sq_q.st == ST_PAR);
    assign gain_flag_o = (sq_q.st == ST_G);
    assign chan_o      = data_beat ? sq_q.ch : '0;

    // R2: the request cycle carries no data flag.
    p_req_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (!iq_flag_o && !gain_flag_o));

    // R4: an acknowledged interleaved I beat is followed by Q.
    p_q_after_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_flag_o && !par_mode_i && ack_i) |=> (req_o && !iq_flag_o && !gain_flag_o));

    // R5: the gain beat follows Q only when enabled.
    p_gain_after_q_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == ST_Q && ack_i && gain_en_i) |=> gain_flag_o);
    p_no_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == ST_Q && ack_i && !gain_en_i) |=> !req_o);

    // R6: a stalled port holds everything.
    p_hold_on_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(bus_o) && $stable(iq_flag_o) &&
                               $stable(gain_flag_o) && $stable(chan_o)));

    // R7: the packed flag stays up while more channels are pending.
    p_par_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == ST_PAR && ack_i && any_i) |=> (req_o && iq_flag_o));

endmodule

// File: rtl/iq_out_port.sv
module iq_out_port #(
    parameter int NCH = 8,
    parameter int SW  = 16,
    parameter int GW  = 12,
    parameter int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_mode_i,
    input  logic              gain_en_i,
    input  logic [NCH-1:0]    smp_vld_i,
    input  logic [NCH*SW-1:0] smp_i_i,
    input  logic [NCH*SW-1:0] smp_q_i,
    input  logic [NCH*GW-1:0] smp_gain_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [SW-1:0]     bus_o,
    output logic              iq_flag_o,
    output logic              gain_flag_o,
    output logic [CHW-1:0]    chan_o,
    output logic [NCH-1:0]    ovf_o
);

    logic [NCH-1:0] pend;
    logic           any;
    logic [CHW-1:0] idx;
    logic           pop;
    logic [SW-1:0]  rd_i;
    logic [SW-1:0]  rd_q;
    logic [GW-1:0]  rd_g;

    iq_slot_store #(.NCH(NCH), .SW(SW), .GW(GW), .CHW(CHW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (smp_vld_i),
        .i_i       (smp_i_i),
        .q_i       (smp_q_i),
        .g_i       (smp_gain_i),
        .pop_i     (pop),
        .pop_idx_i (idx),
        .pend_o    (pend),
        .ovf_o     (ovf_o),
        .rd_i_o    (rd_i),
        .rd_q_o    (rd_q),
        .rd_g_o    (rd_g)
    );

    iq_prio_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .any_o  (any),
        .idx_o  (idx)
    );

    iq_beat_seq #(.SW(SW), .GW(GW), .CHW(CHW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_mode_i  (par_mode_i),
        .gain_en_i   (gain_en_i),
        .ack_i       (ack_i),
        .any_i       (any),
        .idx_i       (idx),
        .rd_i_i      (rd_i),
        .rd_q_i      (rd_q),
        .rd_g_i      (rd_g),
        .pop_o       (pop),
        .req_o       (req_o),
        .bus_o       (bus_o),
        .iq_flag_o   (iq_flag_o),
        .gain_flag_o (gain_flag_o),
        .chan_o      (chan_o)
    );

endmodule

// File: tb/iq_out_port_tb.sv
module iq_out_port_tb;

    localparam int NCH = 8;
    localparam int SW  = 16;
    localparam int GW  = 12;
    localparam int CHW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              par_mode = 1'b0;
    logic              gain_en = 1'b0;
    logic [NCH-1:0]    vld = '0;
    logic [NCH*SW-1:0] di = '0;
    logic [NCH*SW-1:0] dq = '0;
    logic [NCH*GW-1:0] dg = '0;
    logic              ack = 1'b1;
    logic              req;
    logic [SW-1:0]     bus;
    logic              iqf;
    logic              gf;
    logic [CHW-1:0]    chan;
    logic [NCH-1:0]    ovf;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    iq_out_port #(.NCH(NCH), .SW(SW), .GW(GW), .CHW(CHW)) u_dut (
        .clk(clk), .rst_n(rst_n), .par_mode_i(par_mode), .gain_en_i(gain_en),
        .smp_vld_i(vld), .smp_i_i(di), .smp_q_i(dq), .smp_gain_i(dg),
        .ack_i(ack), .req_o(req), .bus_o(bus), .iq_flag_o(iqf),
        .gain_flag_o(gf), .chan_o(chan), .ovf_o(ovf)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic look(logic r, logic [15:0] b, logic f, logic g, logic [2:0] c, string tag);
        chk({tag, " req"},  32'(req),  32'(r));
        chk({tag, " bus"},  32'(bus),  32'(b));
        chk({tag, " iq"},   32'(iqf),  32'(f));
        chk({tag, " gain"}, 32'(gf),   32'(g));
        chk({tag, " chan"}, 32'(chan), 32'(c));
    endtask

    task automatic beat(logic r, logic [15:0] b, logic f, logic g, logic [2:0] c, string tag);
        look(r, b, f, g, c, tag);
        @(negedge clk);
    endtask

    function automatic logic [15:0] f_i(int m, int c, int md);
        return {4'(c), 8'(m), 4'(md)};
    endfunction
    function automatic logic [15:0] f_q(int m, int c, int md);
        return {8'(m), 4'(c), 4'(md + 8)};
    endfunction
    function automatic logic [11:0] f_g(int m, int c);
        return {8'(m) ^ 8'h3C, 4'(c)};
    endfunction

    // Mode 0: interleaved, 1: interleaved with gain, 2: packed.
    task automatic run_burst(int md, int m);
        for (int c = 0; c < NCH; c++) begin
            di[c*SW +: SW] = f_i(m, c, md);
            dq[c*SW +: SW] = f_q(m, c, md);
            dg[c*GW +: GW] = f_g(m, c);
        end
        vld = 8'(m);
        @(negedge clk);
        vld = '0;
        if (md < 2) begin
            for (int c = 0; c < NCH; c++) begin
                if (m[c]) begin
                    beat(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R2 idle");
                    beat(1'b1, 16'h0, 1'b0, 1'b0, 3'd0, "R2 request");
                    beat(1'b1, f_i(m, c, md), 1'b1, 1'b0, 3'(c), "R3 R8 I beat");
                    beat(1'b1, f_q(m, c, md), 1'b0, 1'b0, 3'(c), "R4 Q beat");
                    if (md == 1)
                        beat(1'b1, {f_g(m, c), 4'h0}, 1'b0, 1'b1, 3'(c), "R5 gain beat");
                end
            end
            look(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R2 R5 end");
        end else begin
            beat(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R2 idle");
            beat(1'b1, 16'h0, 1'b0, 1'b0, 3'd0, "R2 request");
            for (int c = 0; c < NCH; c++) begin
                if (m[c])
                    beat(1'b1, {f_i(m, c, md)[15:8], f_q(m, c, md)[15:8]},
                         1'b1, 1'b0, 3'(c), "R7 R8 packed beat");
            end
            look(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R7 flag drop");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        look(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R1 in reset");
        chk("R1 ovf", 32'(ovf), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        look(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R1 after reset");

        // Sweep all channel masks in each format.
        for (int md = 0; md < 3; md++) begin
            par_mode = (md == 2);
            gain_en  = (md != 0);
            for (int m = 1; m < 256; m++) run_burst(md, m);
        end
        chk("R9 no overwrite in sweep", 32'(ovf), 32'h0);

        // Directed stall and overwrite sequence.
        par_mode = 1'b0;
        gain_en  = 1'b1;
        ack      = 1'b0;
        di[3*SW +: SW] = 16'h1234;
        dq[3*SW +: SW] = 16'h5678;
        dg[3*GW +: GW] = 12'hABC;
        vld = 8'h08;
        @(negedge clk);
        vld = '0;
        beat(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R2 idle");
        look(1'b1, 16'h0, 1'b0, 1'b0, 3'd0, "R6 request stalled");
        di[6*SW +: SW] = 16'h1111;
        dq[6*SW +: SW] = 16'h1112;
        dg[6*GW +: GW] = 12'h113;
        vld = 8'h40;
        @(negedge clk);
        di[6*SW +: SW] = 16'h2222;
        dq[6*SW +: SW] = 16'h3333;
        dg[6*GW +: GW] = 12'h444;
        @(negedge clk);
        vld = '0;
        chk("R9 overwrite flag", 32'(ovf), 32'h40);
        for (int k = 0; k < 3; k++) beat(1'b1, 16'h0, 1'b0, 1'b0, 3'd0, "R6 hold request");
        ack = 1'b1;
        @(negedge clk);
        look(1'b1, 16'h1234, 1'b1, 1'b0, 3'd3, "R3 I after stall");
        ack = 1'b0;
        @(negedge clk);
        look(1'b1, 16'h1234, 1'b1, 1'b0, 3'd3, "R6 I held");
        @(negedge clk);
        look(1'b1, 16'h1234, 1'b1, 1'b0, 3'd3, "R6 I held");
        ack = 1'b1;
        @(negedge clk);
        beat(1'b1, 16'h5678, 1'b0, 1'b0, 3'd3, "R4 Q after stall");
        beat(1'b1, 16'hABC0, 1'b0, 1'b1, 3'd3, "R5 gain after stall");
        beat(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R2 idle");
        beat(1'b1, 16'h0, 1'b0, 1'b0, 3'd0, "R2 request");
        beat(1'b1, 16'h2222, 1'b1, 1'b0, 3'd6, "R9 newer I kept");
        beat(1'b1, 16'h3333, 1'b0, 1'b0, 3'd6, "R9 newer Q kept");
        beat(1'b1, 16'h4440, 1'b0, 1'b1, 3'd6, "R9 newer gain kept");
        look(1'b0, 16'h0, 1'b0, 1'b0, 3'd0, "R2 end");
        chk("R9 ovf sticky", 32'(ovf), 32'h40);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule